// File: doc/BRIEF.md
# Frame-Synchronous Bit Descrambler

The block removes the whitening applied by a 7-bit additive scrambler with generator x^7 + x^4 + 1 from a serial stream of decoded bits. It takes one bit per input strobe and returns one bit per output strobe, one cycle later.

In receive mode the block finds the transmitter's seed without any extra storage. The transmitter forces the first seven plaintext bits of every packet to zero, so the first seven scrambled bits it sends are the scrambler's own feedback sequence. The block shifts these bits straight into its state register and outputs zeros for them. From bit index 7 on, the loaded state descrambles the stream directly.

In transmit mode the same update logic acts as the scrambler. A start pulse loads a caller-supplied nonzero seed, and scrambling begins at bit 0.

Top module: `frame_descrambler`

## Requirements
- R1: While rst_ni is low and after its release, bit_o and bit_vld_o are 0 until the first input strobe has been registered.
- R2: bit_vld_o equals bit_vld_i delayed by exactly one clock cycle, and bit_o is 0 in every cycle in which bit_vld_o is 0.
- R3: In receive mode (mode_tx_i = 0 at the start pulse), the first seven strobed bits after sop_i produce bit_o = 0.
- R4: In receive mode, if the stream was scrambled from any seed with its first seven plaintext bits zero, then bit_o equals the plaintext bit for every strobed bit from index 7 onward.
- R5: In transmit mode (mode_tx_i = 1 at the start pulse), sop_i loads seed_i into the state, with seed_i bit 6 as the oldest tap X7 and bit 0 as X1. Every strobed bit, from index 0, gives bit_o = bit_i XOR X7 XOR X4. That same feedback value is then shifted in as the new X1, and each other Xi takes the old X(i-1).
- R6: A stream produced in transmit mode from plaintext that starts with seven zeros, fed back in receive mode, returns that plaintext from bit index 7 onward.
- R7: An sop_i in the middle of a packet restarts the packet. In receive mode it starts a fresh seven-bit seed capture, which makes the next seven outputs zero again.
- R8: Cycles with bit_vld_i = 0 leave the state unchanged, so idle gaps between strobes do not alter any later output bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sop_i | input | 1 | Start-of-packet pulse |
| mode_tx_i | input | 1 | Mode, sampled on sop_i: 1 = scramble with a seed, 0 = descramble with self-recovered seed |
| seed_i | input | 7 | Transmit seed, loaded on sop_i in transmit mode |
| bit_i | input | 1 | Input bit |
| bit_vld_i | input | 1 | Input bit strobe |
| bit_o | output | 1 | Output bit |
| bit_vld_o | output | 1 | Output bit strobe |

## Verification
The assertions assume three things about the inputs. A start pulse never shares a cycle with a bit strobe. The input strobe is low while reset is applied. In transmit mode the seed is never zero, because an all-zero state would never leave zero. The bench raises sop_i alone on its own clock cycle and keeps bit_vld_i low through reset. Every transmit test uses a nonzero seed, and receive tests check output only through the ports, against a bench scrambler run on zero-prefixed plaintext.

// File: rtl/frame_scr_pkg.sv
package frame_scr_pkg;
  localparam int unsigned STATE_W = 7;
  localparam int unsigned TAP_HI  = 7;
  localparam int unsigned TAP_LO  = 4;

  typedef enum logic {
    MODE_RX = 1'b0,
    MODE_TX = 1'b1
  } scr_mode_e;
endpackage

// File: rtl/scr_lfsr.sv
module scr_lfsr #(
  parameter int unsigned STATE_W = frame_scr_pkg::STATE_W,
  parameter int unsigned TAP_HI  = frame_scr_pkg::TAP_HI,
  parameter int unsigned TAP_LO  = frame_scr_pkg::TAP_LO
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [STATE_W-1:0] seed_i,
  input  logic               step_i,
  input  logic               train_i,
  input  logic               din_i,
  output logic               dout_o
);
  logic [STATE_W-1:0] state_q;
  logic               fb;

  // bit 0 is X1, bit STATE_W-1 is X7
  assign fb     = state_q[TAP_HI-1] ^ state_q[TAP_LO-1];
  assign dout_o = din_i ^ fb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
    end else if (load_i) begin
      state_q <= seed_i;
    end else if (step_i) begin
      // seed capture: received bit equals feedback when plaintext is zero
      state_q <= {state_q[STATE_W-2:0], (train_i ? din_i : fb)};
    end
  end
endmodule

// File: rtl/scr_ctrl.sv
module scr_ctrl #(
  parameter int unsigned STATE_W = frame_scr_pkg::STATE_W
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sop_i,
  input  logic mode_tx_i,
  input  logic vld_i,
  output logic train_o,
  output logic mode_o
);
  import frame_scr_pkg::*;
  localparam int unsigned CNT_W = $clog2(STATE_W + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(STATE_W);

  logic [CNT_W-1:0] cnt_q;
  scr_mode_e        mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      mode_q <= MODE_RX;
    end else if (sop_i) begin
      cnt_q  <= '0;
      mode_q <= mode_tx_i ? MODE_TX : MODE_RX;
    end else if (vld_i && cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign mode_o  = (mode_q == MODE_TX);
  assign train_o = (mode_q == MODE_RX) && (cnt_q != CNT_MAX);
endmodule

// File: rtl/frame_descrambler.sv
module frame_descrambler #(
  parameter int unsigned STATE_W = frame_scr_pkg::STATE_W,
  parameter int unsigned TAP_HI  = frame_scr_pkg::TAP_HI,
  parameter int unsigned TAP_LO  = frame_scr_pkg::TAP_LO
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sop_i,
  input  logic               mode_tx_i,
  input  logic [STATE_W-1:0] seed_i,
  input  logic               bit_i,
  input  logic               bit_vld_i,
  output logic               bit_o,
  output logic               bit_vld_o
);
  logic train_w;
  logic mode_w;
  logic dout_w;
  logic step_w;
  logic load_w;

  assign load_w = sop_i && mode_tx_i;
  assign step_w = bit_vld_i && !sop_i;

  scr_ctrl #(.STATE_W(STATE_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sop_i    (sop_i),
    .mode_tx_i(mode_tx_i),
    .vld_i    (step_w),
    .train_o  (train_w),
    .mode_o   (mode_w)
  );

  scr_lfsr #(.STATE_W(STATE_W), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO)) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_w),
    .seed_i (seed_i),
    .step_i (step_w),
    .train_i(train_w),
    .din_i  (bit_i),
    .dout_o (dout_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_o     <= 1'b0;
      bit_vld_o <= 1'b0;
    end else begin
      bit_vld_o <= step_w;
      bit_o     <= step_w && !train_w && dout_w;
    end
  end
endmodule

// File: rtl/frame_descrambler_chk.sv
module frame_descrambler_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sop_i,
  input logic mode_tx_i,
  input logic bit_vld_i,
  input logic bit_o,
  input logic bit_vld_o,
  input logic train_i,
  input logic mode_i
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  p_sop_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sop_i && bit_vld_i));

  p_vld_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> bit_vld_o == $past(bit_vld_i));

  p_idle_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_vld_o |-> !bit_o);

  p_train_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_vld_i && train_i) |=> !bit_o);

  p_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sop_i && !mode_tx_i) |=> train_i);

  p_tx_no_train_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sop_i && mode_tx_i) |=> (mode_i && !train_i));
endmodule

module scr_lfsr_chk #(
  parameter int unsigned STATE_W = 7
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               load_i,
  input logic               step_i,
  input logic [STATE_W-1:0] seed_i,
  input logic [STATE_W-1:0] state_i
);
  p_seed_nz_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> seed_i != '0);

  p_seed_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> state_i == $past(seed_i));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable(state_i));
endmodule

bind frame_descrambler frame_descrambler_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sop_i    (sop_i),
  .mode_tx_i(mode_tx_i),
  .bit_vld_i(bit_vld_i),
  .bit_o    (bit_o),
  .bit_vld_o(bit_vld_o),
  .train_i  (train_w),
  .mode_i   (mode_w)
);

bind scr_lfsr scr_lfsr_chk #(.STATE_W(STATE_W)) u_lfsr_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .load_i (load_i),
  .step_i (step_i),
  .seed_i (seed_i),
  .state_i(state_q)
);

// File: tb/frame_descrambler_tb.sv
module frame_descrambler_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sop_i = 1'b0;
  logic       mode_tx_i = 1'b0;
  logic [6:0] seed_i = '0;
  logic       bit_i = 1'b0;
  logic       bit_vld_i = 1'b0;
  logic       bit_o;
  logic       bit_vld_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  frame_descrambler u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sop_i(sop_i), .mode_tx_i(mode_tx_i),
    .seed_i(seed_i), .bit_i(bit_i), .bit_vld_i(bit_vld_i),
    .bit_o(bit_o), .bit_vld_o(bit_vld_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b (t=%0t)", req, act, exp, $time);
    end
  endtask

  // bench scrambler from R5: out = b ^ X7 ^ X4, shift feedback into X1
  function automatic logic ref_step(inout logic [6:0] s, input logic b);
    logic f;
    f = s[6] ^ s[3];
    s = {s[5:0], f};
    return b ^ f;
  endfunction

  task automatic start(input logic tx, input logic [6:0] sd);
    @(negedge clk_i);
    sop_i = 1'b1; mode_tx_i = tx; seed_i = sd;
    @(negedge clk_i);
    sop_i = 1'b0;
  endtask

  task automatic send(input logic b, input int gap, output logic ob);
    bit_i = b; bit_vld_i = 1'b1;
    @(negedge clk_i);
    bit_vld_i = 1'b0;
    check("R2 vld", bit_vld_o, 1'b1);
    ob = bit_o;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk_i);
      check("R2 idle vld", bit_vld_o, 1'b0);
      check("R2 idle bit", bit_o, 1'b0);
    end
  endtask

  // receive packet: zero prefix + random payload scrambled by bench
  task automatic rx_packet(input logic [6:0] sd, input int nbits, input int gap, input string req);
    logic [6:0] s;
    logic p, c, ob;
    s = sd;
    start(1'b0, 7'h00);
    for (int i = 0; i < nbits; i++) begin
      p = (i < 7) ? 1'b0 : 1'($urandom);
      c = ref_step(s, p);
      send(c, gap, ob);
      if (i < 7) check("R3 capture zero", ob, 1'b0);
      else       check(req, ob, p);
    end
  endtask

  task automatic t_reset;
    #1;
    check("R1 reset vld", bit_vld_o, 1'b0);
    check("R1 reset bit", bit_o, 1'b0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 post vld", bit_vld_o, 1'b0);
    check("R1 post bit", bit_o, 1'b0);
  endtask

  task automatic t_rx_back_to_back;
    rx_packet(7'b1011101, 60, 0, "R4 b2b");
    rx_packet(7'b1111111, 30, 0, "R4 all-ones seed");
  endtask

  task automatic t_rx_gaps;
    rx_packet(7'b0100110, 30, 3, "R8 gaps");
  endtask

  task automatic t_tx;
    logic [6:0] s;
    logic p, ob;
    s = 7'b1001011;
    start(1'b1, s);
    for (int i = 0; i < 40; i++) begin
      p = 1'($urandom);
      send(p, i % 2, ob);
      check("R5 tx", ob, ref_step(s, p));
    end
  endtask

  task automatic t_loop;
    logic [63:0] plain, cipher;
    logic ob;
    for (int i = 0; i < 64; i++) plain[i] = (i < 7) ? 1'b0 : 1'($urandom);
    start(1'b1, 7'b0000001);
    for (int i = 0; i < 64; i++) begin
      send(plain[i], 0, ob);
      cipher[i] = ob;
    end
    start(1'b0, 7'h00);
    for (int i = 0; i < 64; i++) begin
      send(cipher[i], 0, ob);
      check(i < 7 ? "R3 loop" : "R6 loop", ob, i < 7 ? 1'b0 : plain[i]);
    end
  endtask

  task automatic t_restart;
    logic [6:0] s;
    logic ob;
    s = 7'b0110011;
    start(1'b0, 7'h00);
    for (int i = 0; i < 20; i++) send(ref_step(s, (i < 7) ? 1'b0 : 1'b1), 0, ob);
    rx_packet(7'b1100001, 25, 0, "R7 restart");
  endtask

  initial begin : main
    t_reset();
    t_rx_back_to_back();
    t_rx_gaps();
    t_tx();
    t_loop();
    t_restart();
    done = 1'b1;
  end

  initial begin : watchdog
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk_i);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule